// File: doc/BRIEF.md
# SPI flash read sequencer

This block runs a fixed fetch from a serial NOR flash through an SPI byte master that sits outside it. One pulse on `start` sends the flash the wake-up opcode and then closes that frame. The block then waits out the flash's wake-up recovery time. Next it opens a read frame that carries the read opcode and a 24-bit start address, with the most significant byte first. It then clocks in a fixed number of data bytes by sending dummy bytes. The frame is closed, the flash gets the power-down opcode in a frame of its own, and `done` pulses.

The block talks to the byte master through a command port and a status port. To send a byte, it pulses `cmd_load` with `cmd_release` low and puts the byte on `cmd_byte`. To raise chip select without sending anything, it pulses `cmd_load` with `cmd_release` high. The master raises `mst_busy` on the clock edge that takes a send command. It drops `mst_busy` with the received byte on `mst_rx` once the exchange is over. A release command leaves `mst_busy` low.

Each data byte goes to a UART transmitter over a valid/ready handshake. The block issues no further command until the transmitter has taken the byte.

Top module: `flash_fetch_seq`

## Requirements
- R1: After reset and between runs, the block keeps `cmd_load`, `tx_valid` and `done` low.
- R2: A run opens with a send of 0xAB. A release command follows it.
- R3: The gap from the release after the wake-up to the send of the read opcode is at least ceil(CLK_HZ·WAKE_NS/10^9) clock cycles. That is 300 cycles at 100 MHz and 3000 ns.
- R4: The read frame sends 0x03 and then the address bytes 0x04, 0x00 and 0x00, most significant first. No release comes between these bytes.
- R5: In the same frame come NBYTES sends of dummy byte 0x00 (four by default). Each received byte is shown on `tx_data` with `tx_valid` high, in the order it was read. The byte stays unchanged until `tx_ready` is seen high.
- R6: `cmd_load` is never high while `tx_valid` is high. The next exchange starts only after the handshake.
- R7: After the last data byte, the commands are a release, then a send of 0xB9, then a release.
- R8: `cmd_load` is high for single cycles only, and never while `mst_busy` is high.
- R9: `done` is high for exactly one cycle per run. This comes after the final release has finished.
- R10: A `start` pulse while a run is in progress has no effect on the command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when the block is idle |
| done | output | 1 | One-cycle pulse at the end of a run |
| cmd_load | output | 1 | Command strobe to the byte master |
| cmd_release | output | 1 | 1: raise chip select only; 0: send `cmd_byte` |
| cmd_byte | output | 8 | Byte to be sent |
| mst_busy | input | 1 | Byte master is exchanging a byte |
| mst_rx | input | 8 | Byte received by the master, valid once busy falls |
| tx_valid | output | 1 | Data byte offered to the UART |
| tx_data | output | 8 | Data byte |
| tx_ready | input | 1 | UART accepts the byte |

## Verification
A wrong step counter or state shows at the very next `cmd_load`. That strobe carries a byte or a release flag that differs from the fixed command list, or it comes while the master is still busy. A short wake-up timer shows up as a read opcode sent too soon after the first release. A fault in the hold register shows as changing `tx_data` during a stall, or as a command sent while a byte is still on offer. Both appear within one byte exchange.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAITB,
    S_DELAY,
    S_FWD,
    S_DONE
  } seq_state_t;

  typedef struct packed {
    logic       rel;
    logic [7:0] data;
  } spi_cmd_t;

  localparam logic [7:0] OP_WAKE  = 8'hAB;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_DUMMY = 8'h00;

  // Wake-up recovery in clock cycles, rounded up, never below one.
  function automatic int unsigned wake_cycles(input int unsigned clk_hz,
                                              input int unsigned wait_ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(clk_hz) * longint'(wait_ns);
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/fs_step_decode.sv
module fs_step_decode
  import flash_seq_pkg::*;
#(
  parameter int unsigned NBYTES    = 4,
  parameter logic [23:0] READ_ADDR = 24'h040000,
  parameter int unsigned STEP_W    = 4
) (
  input  logic [STEP_W-1:0] step,
  output spi_cmd_t          cmd,
  output logic              is_data,
  output logic              is_wake_rel,
  output logic              is_last
);
  localparam logic [STEP_W-1:0] ST_WAKE  = STEP_W'(0);
  localparam logic [STEP_W-1:0] ST_WREL  = STEP_W'(1);
  localparam logic [STEP_W-1:0] ST_READ  = STEP_W'(2);
  localparam logic [STEP_W-1:0] ST_A2    = STEP_W'(3);
  localparam logic [STEP_W-1:0] ST_A1    = STEP_W'(4);
  localparam logic [STEP_W-1:0] ST_A0    = STEP_W'(5);
  localparam logic [STEP_W-1:0] ST_DATA0 = STEP_W'(6);
  localparam logic [STEP_W-1:0] ST_RREL  = STEP_W'(6 + NBYTES);
  localparam logic [STEP_W-1:0] ST_SLEEP = STEP_W'(7 + NBYTES);
  localparam logic [STEP_W-1:0] ST_LAST  = STEP_W'(8 + NBYTES);

  always_comb begin
    cmd = '{rel: 1'b1, data: OP_DUMMY};
    if (step == ST_WAKE)                        cmd = '{rel: 1'b0, data: OP_WAKE};
    else if (step == ST_READ)                   cmd = '{rel: 1'b0, data: OP_READ};
    else if (step == ST_A2)                     cmd = '{rel: 1'b0, data: READ_ADDR[23:16]};
    else if (step == ST_A1)                     cmd = '{rel: 1'b0, data: READ_ADDR[15:8]};
    else if (step == ST_A0)                     cmd = '{rel: 1'b0, data: READ_ADDR[7:0]};
    else if (step >= ST_DATA0 && step < ST_RREL) cmd = '{rel: 1'b0, data: OP_DUMMY};
    else if (step == ST_SLEEP)                  cmd = '{rel: 1'b0, data: OP_SLEEP};
  end

  assign is_data     = (step >= ST_DATA0) && (step < ST_RREL);
  assign is_wake_rel = (step == ST_WREL);
  assign is_last     = (step == ST_LAST);
endmodule

// File: rtl/fs_wait_timer.sv
module fs_wait_timer #(
  parameter int unsigned CYCLES = 300,
  parameter int unsigned CNT_W  = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expired
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (arm) begin
      cnt     <= LOAD;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign expired = running && (cnt == '0);
endmodule

// File: rtl/fs_tx_hold.sv
module fs_tx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic [7:0] din,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       accept
);
  assign accept = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (capture) begin
      tx_valid <= 1'b1;
      tx_data  <= din;
    end else if (accept) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_fetch_seq.sv
module flash_fetch_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned WAKE_NS   = 3000,
  parameter int unsigned NBYTES    = 4,
  parameter logic [23:0] READ_ADDR = 24'h040000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       done,
  output logic       cmd_load,
  output logic       cmd_release,
  output logic [7:0] cmd_byte,
  input  logic       mst_busy,
  input  logic [7:0] mst_rx,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready
);
  localparam int unsigned N_STEPS  = NBYTES + 9;
  localparam int unsigned STEP_W   = $clog2(N_STEPS);
  localparam int unsigned WAIT_CYC = wake_cycles(CLK_HZ, WAKE_NS);

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  spi_cmd_t          cmd;
  logic              is_data, is_wake_rel, is_last;

  // named internal events
  logic issue_fire, byte_done, tx_accept, delay_expired, delay_arm, rx_capture, in_idle;

  assign issue_fire = (state == S_ISSUE);
  assign byte_done  = (state == S_WAITB) && !mst_busy;
  assign delay_arm  = byte_done && is_wake_rel;
  assign rx_capture = byte_done && is_data;
  assign in_idle    = (state == S_IDLE);

  fs_step_decode #(
    .NBYTES(NBYTES), .READ_ADDR(READ_ADDR), .STEP_W(STEP_W)
  ) u_decode (
    .step(step), .cmd(cmd), .is_data(is_data),
    .is_wake_rel(is_wake_rel), .is_last(is_last)
  );

  fs_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(delay_arm), .expired(delay_expired)
  );

  fs_tx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .capture(rx_capture), .din(mst_rx),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .accept(tx_accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      step  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_ISSUE;
          step  <= '0;
        end
        S_ISSUE: state <= S_WAITB;
        S_WAITB: if (!mst_busy) begin
          if (is_data)          state <= S_FWD;
          else if (is_wake_rel) state <= S_DELAY;
          else if (is_last)     state <= S_DONE;
          else begin
            step  <= step + 1'b1;
            state <= S_ISSUE;
          end
        end
        S_DELAY: if (delay_expired) begin
          step  <= step + 1'b1;
          state <= S_ISSUE;
        end
        S_FWD: if (tx_accept) begin
          step  <= step + 1'b1;
          state <= S_ISSUE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_load    = issue_fire;
  assign cmd_release = cmd.rel;
  assign cmd_byte    = cmd.data;
  assign done        = (state == S_DONE);
endmodule

// File: rtl/fs_seq_checker.sv
module fs_seq_checker #(
  parameter int unsigned WAIT_CYC = 300
) (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       cmd_load,
  input logic       cmd_release,
  input logic [7:0] cmd_byte,
  input logic       mst_busy,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       in_idle
);
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)             gap <= '0;
    else if (cmd_load)      gap <= '0;
    else if (gap != '1)     gap <= gap + 1'b1;
  end

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (!cmd_load && !tx_valid));

  a_r3_wake_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !cmd_release && cmd_byte == 8'h03) |-> (gap >= WAIT_CYC));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r6_no_load_while_holding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |-> !tx_valid);

  a_r8_load_master_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |-> !mst_busy);

  a_r8_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> !cmd_load);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind flash_fetch_seq fs_seq_checker #(.WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .cmd_load(cmd_load),
  .cmd_release(cmd_release), .cmd_byte(cmd_byte), .mst_busy(mst_busy),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .in_idle(in_idle)
);

// File: tb/flash_fetch_seq_bench.sv
module flash_fetch_seq_bench;
  localparam int EXP_GAP = (3000 + 9) / 10;  // 3 us at a 10 ns period, rounded up

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, cmd_load, cmd_release, tx_valid, tx_ready;
  logic [7:0] cmd_byte, tx_data, mst_rx;
  logic mst_busy;

  always #5 clk = ~clk;

  flash_fetch_seq u_flash_fetch_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .cmd_load(cmd_load), .cmd_release(cmd_release), .cmd_byte(cmd_byte),
    .mst_busy(mst_busy), .mst_rx(mst_rx),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return (a[7:0] * 8'd37 + 8'h5A) ^ a[15:8];
  endfunction

  // byte master and flash model
  int          bcnt;
  int          fidx;
  logic [7:0]  op;
  logic [23:0] addr;
  logic [7:0]  rx_next;
  always @(posedge clk) begin
    if (!rst_n) begin
      mst_busy <= 1'b0; mst_rx <= 8'h00; bcnt <= 0; fidx <= 0;
      op <= 8'h00; addr <= '0; rx_next <= 8'hFF;
    end else if (cmd_load) begin
      if (cmd_release) fidx <= 0;
      else begin
        mst_busy <= 1'b1;
        bcnt     <= 16;
        fidx     <= fidx + 1;
        if (fidx == 0) op <= cmd_byte;
        if (fidx >= 1 && fidx <= 3) addr <= {addr[15:0], cmd_byte};
        rx_next <= (op == 8'h03 && fidx >= 4) ? mem_byte(addr + 24'(fidx - 4)) : 8'hFF;
      end
    end else if (mst_busy) begin
      if (bcnt == 1) begin
        mst_busy <= 1'b0;
        mst_rx   <= rx_next;
      end
      bcnt <= bcnt - 1;
    end
  end

  // UART ready model
  int stall_len = 0;
  int vcnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      tx_ready <= 1'b0; vcnt <= 0;
    end else begin
      vcnt     <= tx_valid ? vcnt + 1 : 0;
      tx_ready <= (stall_len == 0) ? 1'b1 : (tx_valid && vcnt + 1 >= stall_len);
    end
  end

  // scoreboard
  logic [8:0] exp_cmd[$];
  string      exp_tag[$];
  logic [7:0] exp_tx[$];
  int         cyc = 0;
  int         last_rel = 0;
  int         done_cnt = 0;
  bit         prev_done = 0;
  bit         hold_chk = 0;
  logic [7:0] held;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cmd_load) begin
        chk(!mst_busy, "R8 load while busy", int'(mst_busy), 0);
        chk(!tx_valid, "R6 load while byte held", int'(tx_valid), 0);
        if (exp_cmd.size() == 0) chk(0, "R10 unexpected command", {cmd_release, cmd_byte}, 0);
        else begin
          logic [8:0] e;
          string      t;
          e = exp_cmd.pop_front();
          t = exp_tag.pop_front();
          if (e[8]) chk(cmd_release == 1'b1, t, {cmd_release, cmd_byte}, e);
          else      chk({cmd_release, cmd_byte} == e, t, {cmd_release, cmd_byte}, e);
          if (!e[8] && e[7:0] == 8'h03 && t == "R4 read opcode")
            chk(cyc - last_rel >= EXP_GAP, "R3 wake gap", cyc - last_rel, EXP_GAP);
        end
        if (cmd_release) last_rel = cyc;
      end
      if (hold_chk)
        chk(tx_valid && tx_data == held, "R5 held byte stable", {tx_valid, tx_data}, {1'b1, held});
      hold_chk = tx_valid && !tx_ready;
      held     = tx_data;
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) chk(0, "R5 unexpected tx byte", tx_data, 0);
        else begin
          logic [7:0] b;
          b = exp_tx.pop_front();
          chk(tx_data == b, "R5 tx data", tx_data, b);
        end
      end
      if (done) begin
        done_cnt++;
        chk(!prev_done, "R9 done width", 1, 0);
      end
      prev_done = done;
    end
  end

  task automatic push_cmd(input bit rel, input logic [7:0] b, input string tag);
    exp_cmd.push_back({rel, b});
    exp_tag.push_back(tag);
  endtask

  task automatic run_seq(input int stall, input bit poke_start);
    int d0;
    stall_len = stall;
    push_cmd(0, 8'hAB, "R2 wake opcode");
    push_cmd(1, 8'h00, "R2 wake release");
    push_cmd(0, 8'h03, "R4 read opcode");
    push_cmd(0, 8'h04, "R4 addr hi");
    push_cmd(0, 8'h00, "R4 addr mid");
    push_cmd(0, 8'h00, "R4 addr lo");
    for (int i = 0; i < 4; i++) begin
      push_cmd(0, 8'h00, "R5 dummy");
      exp_tx.push_back(mem_byte(24'h040000 + 24'(i)));
    end
    push_cmd(1, 8'h00, "R7 read release");
    push_cmd(0, 8'hB9, "R7 sleep opcode");
    push_cmd(1, 8'h00, "R7 sleep release");
    d0 = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (400) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int k = 0; k < 5000 && done_cnt == d0; k++) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 one done per run", done_cnt - d0, 1);
    chk(exp_cmd.size() == 0, "R7 command list consumed", exp_cmd.size(), 0);
    chk(exp_tx.size() == 0, "R5 all bytes forwarded", exp_tx.size(), 0);
    repeat (30) @(negedge clk);
    chk(!cmd_load && !tx_valid && !done, "R1 quiet after run",
        {cmd_load, tx_valid, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_load && !tx_valid && !done, "R1 reset state", {cmd_load, tx_valid, done}, 0);
    run_seq(0, 0);
    run_seq(3, 0);
    run_seq(7, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule